// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one self-contained DMA channel. Software programs a source address, a destination address, a byte count and a 32-bit control word through a small word-addressed register port. Setting the control word's top bit starts the channel. The channel then moves data one beat at a time over a word-wide memory port: a read from the source, followed by a write of the captured word to the destination. Each side of the transfer has its own data width, burst length and addressing mode. A side marked as a device keeps a fixed address. A memory side advances its address after every beat.

When the count runs out, the channel goes idle and pulses `done_o`. It also pulses `half_o` once half of the count has been moved. In continuous mode the channel instead reloads its programmed addresses and count, then keeps running. Clearing the top control bit while the channel is busy aborts the transfer. When either side is a device, every burst waits for a peripheral request input before it begins.

Top module: `dma_channel`

## Requirements
- R1: Writing the control register (offset 0x00) with bit 31 set while idle makes `busy_o` high on the next cycle, and the first memory request is a read of the programmed source address.
- R2: Register offsets are 0x00 control, 0x04 source address, 0x08 destination address and 0x0C byte count; each reads back its programmed value. Control bit 31 reads as the busy state and bit 30 selects continuous mode. The source side uses control bits 15:0, with width at 10:9, burst at 8:7 and the device flag at 5. The destination side uses the same layout 16 bits higher.
- R3: Width codes 0, 1 and 2 mean 1, 2 and 4 bytes (code 3 is treated as 4). The beat size is the smaller of the two side widths, and `mem_size_o` carries its code. Each beat is one read followed by one write of the data read, unchanged.
- R4: After each beat, a memory-side address advances by the beat size; a device-side address stays fixed.
- R5: The count drops by the beat size each beat. A remainder smaller than the beat size ends after one more beat. A zero count completes with no memory access.
- R6: On completion the channel goes idle, `done_o` pulses for exactly one cycle and control bit 31 reads 0.
- R7: `half_o` pulses once, on the beat where the remaining count first falls to at most half of the programmed count.
- R8: Writing the control register with bit 31 clear while busy stops the channel on the next cycle, with no further requests and no `done_o`. This holds even when it coincides with the final write grant.
- R9: While busy, writes to the address and count registers, and to control fields other than bit 31, are ignored.
- R10: With bit 30 set, completion still pulses `done_o`, but the addresses and count reload and the channel stays busy.
- R11: If either side is a device, each burst starts only in a cycle with `dreq_i` high. It then runs its full length, which is the larger of the two burst codes (0, 1, 2 meaning 1, 4, 8 beats, with code 3 treated as 8). All-memory transfers ignore `dreq_i`.
- R12: A memory request holds its address and direction until `mem_gnt_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register byte offset within the channel window |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| dreq_i | input | 1 | Peripheral request, gates burst start when a device side exists |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address of the access |
| mem_size_o | output | 2 | Beat width code |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with the read grant |
| mem_gnt_i | input | 1 | Access accepted this cycle |
| busy_o | output | 1 | Channel is running |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| half_o | output | 1 | One-cycle half-count pulse |

## Verification
Abort and completion can fall in the same cycle. The final write grant of a transfer can arrive in exactly the cycle that software clears the load bit. To provoke this, the bench waits until the last write request of a single-beat transfer is on the bus, then issues the abort write in that same cycle while the grant is high. Abort must win: the write lands in memory, but `busy_o` drops and `done_o` never pulses. A second overlap is checked too: a register write arriving while the channel is stalled mid-beat must leave the running transfer's addresses and count untouched.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RD, ST_WR} dma_st_e;

  typedef struct packed {
    logic [1:0] width;
    logic [1:0] burst;
    logic       dev;
  } side_cfg_t;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;

  localparam int LOAD_BIT = 31;
  localparam int CONT_BIT = 30;

  function automatic side_cfg_t side_of(input logic [15:0] h);
    side_cfg_t s;
    s.width = (h[10:9] == 2'd3) ? 2'd2 : h[10:9];
    s.burst = (h[8:7] == 2'd3) ? 2'd2 : h[8:7];
    s.dev   = h[5];
    return s;
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] c);
    case (c)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] burst_beats(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    idx_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  output logic [30:0]   ctrl_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          start_o,
  output logic          abort_o
);

  logic [30:0]   ctrl_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ctrl;

  assign wr_ctrl = we_i && (idx_i == REG_CTRL);
  assign start_o = wr_ctrl && wdata_i[LOAD_BIT] && !busy_i;
  assign abort_o = wr_ctrl && !wdata_i[LOAD_BIT] && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else if (we_i && !busy_i) begin
      case (idx_i)
        REG_CTRL: ctrl_q <= wdata_i[30:0];
        REG_SRC:  src_q  <= wdata_i[AW-1:0];
        REG_DST:  dst_q  <= wdata_i[AW-1:0];
        REG_CNT:  cnt_q  <= wdata_i[CW-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      REG_CTRL: rdata_o = {busy_i, ctrl_q};
      REG_SRC:  rdata_o = 32'(src_q);
      REG_DST:  rdata_o = 32'(dst_q);
      REG_CNT:  rdata_o = 32'(cnt_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/dma_ch_side.sv
module dma_ch_side #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ini_i,
  input  logic          adv_i,
  input  logic          fixed_i,
  input  logic [2:0]    step_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (load_i)            addr_q <= ini_i;
    else if (adv_i && !fixed_i) addr_q <= addr_q + AW'(step_i);
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_ch_engine.sv
module dma_ch_engine
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [30:0]   ctrl_i,
  input  logic [AW-1:0] src_ini_i,
  input  logic [AW-1:0] dst_ini_i,
  input  logic [CW-1:0] cnt_ini_i,
  input  logic          dreq_i,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          half_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [31:0]   mem_wdata_o
);

  localparam int NSIDE = 2;

  dma_st_e       st_q;
  logic [CW-1:0] cnt_q, cnt_nxt, half_thr;
  logic [3:0]    burst_left_q, beats;
  logic [31:0]   data_q;
  side_cfg_t     cfg [NSIDE];
  logic [1:0]    beat_code, burst_code;
  logic [2:0]    step;
  logic          conti, need_dreq, reload, adv, last_gnt;
  logic [AW-1:0] ini  [NSIDE];
  logic [AW-1:0] addr [NSIDE];
  logic          unused_ctrl;

  assign cfg[0] = side_of(ctrl_i[15:0]);
  assign cfg[1] = side_of({1'b0, ctrl_i[30:16]});
  assign conti  = ctrl_i[CONT_BIT];
  assign unused_ctrl = ^{ctrl_i[4:0], ctrl_i[6], ctrl_i[14:11], ctrl_i[20:16], ctrl_i[22], ctrl_i[29:27]};

  assign beat_code  = (cfg[0].width < cfg[1].width) ? cfg[0].width : cfg[1].width;
  assign burst_code = (cfg[0].burst > cfg[1].burst) ? cfg[0].burst : cfg[1].burst;
  assign step       = width_bytes(beat_code);
  assign beats      = burst_beats(burst_code);
  assign need_dreq  = cfg[0].dev || cfg[1].dev;

  assign cnt_nxt  = (cnt_q <= CW'(step)) ? '0 : cnt_q - CW'(step);
  assign half_thr = cnt_ini_i >> 1;
  assign last_gnt = (st_q == ST_WR) && mem_gnt_i;
  assign adv      = last_gnt && !abort_i;
  assign reload   = (st_q == ST_ARM) && (cnt_q == '0) && conti && !abort_i;

  assign ini[0] = src_ini_i;
  assign ini[1] = dst_ini_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_ch_side #(.AW(AW)) u_side (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (start_i || reload),
      .ini_i   (ini[s]),
      .adv_i   (adv),
      .fixed_i (cfg[s].dev),
      .step_i  (step),
      .addr_o  (addr[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      burst_left_q <= '0;
      data_q       <= '0;
      done_o       <= 1'b0;
      half_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      half_o <= 1'b0;
      if (abort_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (start_i) begin
            st_q  <= ST_ARM;
            cnt_q <= cnt_ini_i;
          end
          ST_ARM: begin
            if (cnt_q == '0) begin
              done_o <= 1'b1;
              if (conti) cnt_q <= cnt_ini_i;
              else       st_q  <= ST_IDLE;
            end else if (!need_dreq || dreq_i) begin
              burst_left_q <= beats - 4'd1;
              st_q         <= ST_RD;
            end
          end
          ST_RD: if (mem_gnt_i) begin
            data_q <= mem_rdata_i;
            st_q   <= ST_WR;
          end
          ST_WR: if (mem_gnt_i) begin
            cnt_q <= cnt_nxt;
            if (cnt_q > half_thr && cnt_nxt <= half_thr) half_o <= 1'b1;
            if (cnt_nxt == '0 || burst_left_q == '0) begin
              st_q <= ST_ARM;
            end else begin
              burst_left_q <= burst_left_q - 4'd1;
              st_q         <= ST_RD;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR) ? addr[1] : addr[0];
  assign mem_size_o  = beat_code;
  assign mem_wdata_o = data_q;

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [4:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          dreq_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_gnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          half_o
);

  logic [30:0]   ctrl;
  logic [AW-1:0] src_ini, dst_ini;
  logic [CW-1:0] cnt_ini;
  logic          start, abort, busy;
  logic [1:0]    unused_addr;

  assign unused_addr = cfg_addr_i[1:0];

  dma_ch_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_addr_i[4:2]),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .busy_i  (busy),
    .ctrl_o  (ctrl),
    .src_o   (src_ini),
    .dst_o   (dst_ini),
    .cnt_o   (cnt_ini),
    .start_o (start),
    .abort_o (abort)
  );

  dma_ch_engine #(.AW(AW), .CW(CW)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .abort_i     (abort),
    .ctrl_i      (ctrl),
    .src_ini_i   (src_ini),
    .dst_ini_i   (dst_ini),
    .cnt_ini_i   (cnt_ini),
    .dreq_i      (dreq_i),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy),
    .done_o      (done_o),
    .half_o      (half_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [4:0]    cfg_addr_i,
  input logic [31:0]   cfg_wdata_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_gnt_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          half_o
);

  logic ctrl_wr;
  logic unused_chk;

  assign ctrl_wr    = cfg_we_i && (cfg_addr_i[4:2] == 3'd0);
  assign unused_chk = ^{cfg_addr_i[1:0], cfg_wdata_i[30:0]};

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && cfg_wdata_i[31] && !busy_o |=> busy_o);

  p_req_in_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_half_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |=> !half_o);

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !cfg_wdata_i[31] && busy_o |=> !busy_o && !done_o && !mem_req_o);

  p_hold_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

endmodule

bind dma_channel dma_channel_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .half_o      (half_o)
);

// File: tb/dma_channel_test.sv
module dma_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dreq = 1'b1;
  logic        mem_req, mem_we, busy, done, half;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        gnt_en = 1'b1;
  logic        clr_mon = 1'b0;
  logic [31:0] mem [64];

  int n_chk = 0, n_fail = 0;
  int rd_cnt, wr_cnt, done_cnt, half_cnt, half_at;
  logic [31:0] last_src, last_dst;
  bit finished = 0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:2]];

  dma_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .dreq_i(dreq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_gnt_i(gnt_en), .busy_o(busy), .done_o(done), .half_o(half)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) mem[k] <= 32'hA500_0000 + k;
    end
    if (clr_mon || !rst_n) begin
      rd_cnt <= 0; wr_cnt <= 0; done_cnt <= 0; half_cnt <= 0; half_at <= -1;
      last_src <= 32'hFFFF_FFFF; last_dst <= 32'hFFFF_FFFF;
    end else begin
      if (mem_req && gnt_en) begin
        if (mem_we) begin
          wr_cnt <= wr_cnt + 1; last_dst <= mem_addr;
          mem[mem_addr[7:2]] <= mem_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1; last_src <= mem_addr;
        end
      end
      if (done) done_cnt <= done_cnt + 1;
      if (half) begin half_cnt <= half_cnt + 1; half_at <= wr_cnt; end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); clr_mon = 1'b1;
    @(negedge clk); clr_mon = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int c = 0; c < 400 && done_cnt < n; c++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] cnt;
    logic [31:0] beats;
    logic [31:0] lsrc;
    logic [31:0] ldst;
  } vec_t;

  // ctrl bits: [31] load, [10:9]/[26:25] width, [5]/[21] device
  localparam vec_t VECS [5] = '{
    '{32'h8400_0400, 32'h000, 32'h080, 32'd16, 32'd4, 32'h00C, 32'h08C},
    '{32'h8000_0000, 32'h100, 32'h180, 32'd5,  32'd5, 32'h104, 32'h184},
    '{32'h8200_0220, 32'h040, 32'h0C0, 32'd6,  32'd3, 32'h040, 32'h0C4},
    '{32'h8020_0400, 32'h010, 32'h200, 32'd3,  32'd3, 32'h012, 32'h200},
    '{32'h8400_0400, 32'h000, 32'h080, 32'd0,  32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finish");
    summary();
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(!busy && !done && !half, "R6 reset outputs", {busy, done, half}, 0);
    check(!mem_req, "R12 reset no request", mem_req, 0);
    rd_reg(5'h00, rv);
    check(rv == 0, "R2 reset control", rv, 0);

    // table walk
    for (int i = 0; i < 5; i++) begin
      clear_mon();
      wr_reg(5'h04, VECS[i].src);
      wr_reg(5'h08, VECS[i].dst);
      wr_reg(5'h0C, VECS[i].cnt);
      rd_reg(5'h0C, rv);
      check(rv == VECS[i].cnt, "R2 count readback", rv, VECS[i].cnt);
      wr_reg(5'h00, VECS[i].ctrl);
      check(busy, "R1 busy after load", busy, 1);
      wait_done(1);
      repeat (2) @(negedge clk);
      check(done_cnt == 1, "R6 one done pulse", done_cnt, 1);
      check(!busy, "R6 idle after end", busy, 0);
      check(rd_cnt == VECS[i].beats && wr_cnt == VECS[i].beats, "R5 beat count",
            rd_cnt, VECS[i].beats);
      check(last_src == VECS[i].lsrc, "R4 last source address", last_src, VECS[i].lsrc);
      check(last_dst == VECS[i].ldst, "R4 last destination address", last_dst, VECS[i].ldst);
      rd_reg(5'h00, rv);
      check(rv[31] == 1'b0, "R6 load bit cleared", rv[31], 0);
      if (i == 0)
        for (int k = 0; k < 4; k++)
          check(mem[32+k] == mem[k], "R3 data copied", mem[32+k], mem[k]);
    end

    // R9: writes while busy ignored; R7 half pulse
    clear_mon();
    wr_reg(5'h04, 32'h020);
    wr_reg(5'h08, 32'h0A0);
    wr_reg(5'h0C, 32'd8);
    gnt_en = 1'b0;
    wr_reg(5'h00, 32'h8000_0000);
    wr_reg(5'h04, 32'h055);
    wr_reg(5'h0C, 32'd3);
    wr_reg(5'h00, 32'h8400_0400);
    rd_reg(5'h04, rv);
    check(rv == 32'h020, "R9 source held while busy", rv, 32'h020);
    rd_reg(5'h0C, rv);
    check(rv == 32'd8, "R9 count held while busy", rv, 8);
    rd_reg(5'h00, rv);
    check(rv == 32'h8000_0000, "R9 control fields held", rv, 32'h8000_0000);
    check(mem_req && !mem_we && mem_addr == 32'h020, "R12 request held at source", mem_addr, 32'h020);
    gnt_en = 1'b1;
    wait_done(1);
    repeat (2) @(negedge clk);
    check(wr_cnt == 8 && last_src == 32'h027, "R9 transfer unchanged", last_src, 32'h027);
    check(half_cnt == 1 && half_at == 4, "R7 half pulse at midpoint", half_at, 4);

    // R11: dreq gating with 4-beat bursts, device source
    clear_mon();
    dreq = 1'b0;
    wr_reg(5'h04, 32'h300);
    wr_reg(5'h08, 32'h000);
    wr_reg(5'h0C, 32'd16);
    wr_reg(5'h00, 32'h8000_00A0);
    repeat (10) @(negedge clk);
    check(rd_cnt == 0, "R11 no access without request", rd_cnt, 0);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    repeat (20) @(negedge clk);
    check(wr_cnt == 4, "R11 one burst of four", wr_cnt, 4);
    check(last_src == 32'h300, "R4 device source fixed", last_src, 32'h300);
    wr_reg(5'h00, 32'h0000_0000);
    check(!busy, "R8 abort stops", busy, 0);
    repeat (4) @(negedge clk);
    check(done_cnt == 0 && wr_cnt == 4, "R8 no done after abort", done_cnt, 0);
    dreq = 1'b1;

    // R10: continuous mode
    clear_mon();
    wr_reg(5'h04, 32'h000);
    wr_reg(5'h08, 32'h080);
    wr_reg(5'h0C, 32'd8);
    wr_reg(5'h00, 32'hC400_0400);
    wait_done(2);
    @(negedge clk);
    check(done_cnt == 2, "R10 repeated done", done_cnt, 2);
    check(busy, "R10 stays busy", busy, 1);
    check(rd_cnt >= 4 && rd_cnt <= 5, "R10 reload count", rd_cnt, 4);
    wr_reg(5'h00, 32'h0000_0000);
    check(!busy, "R8 abort continuous", busy, 0);

    // R8: abort coincides with final write grant
    clear_mon();
    wr_reg(5'h0C, 32'd4);
    wr_reg(5'h00, 32'h8400_0400);
    for (int c = 0; c < 50 && !(mem_req && mem_we); c++) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'h00; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    check(!busy, "R8 abort wins over end", busy, 0);
    repeat (5) @(negedge clk);
    check(done_cnt == 0, "R8 no done on race", done_cnt, 0);
    check(wr_cnt == 1 && !mem_req, "R8 last write landed, no more", wr_cnt, 1);

    summary();
  end

endmodule